// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Sequencer

This block runs a chain of serial 16-bit sampling converters from the host side. The converters are wired as a shift chain. The data input of the converter farthest from the host is held at logic low. The data output of the converter nearest the host is the only data line that returns to this block.

On a start request the block latches the busy-indicator choice. It parks the serial clock at the level that encodes that choice and raises the convert line. The convert line stays high through the conversion and the whole readout.

Without the busy indicator, the block waits a fixed, parameterised worst-case conversion time. With the busy indicator, it waits for the returning data line to go from low to high. It then issues the right number of serial clock pulses and samples the returning line once per pulse. The bit stream is split into one word per converter, and all words are presented together with a one-cycle strobe.

After each readout the convert line is held low for a minimum acquisition window. Start requests that arrive while a sequence is under way are dropped. All timing is counted in system clock cycles. The chain length, the word width, the serial clock half-period, the conversion wait and the acquisition window are all parameters.

Top module: `chain_adc_reader`

## Requirements
- R1: A start request in the idle state latches `busy_en_i`. The serial clock output then takes that level (0 = no busy indicator, 1 = busy indicator) one cycle before the convert output rises. It keeps that level in the first cycle with convert high and is low from the next cycle until readout begins. Later changes of `busy_en_i` have no effect on a sequence already started.
- R2: The convert output stays high from its rising edge through the whole conversion wait and readout. It falls in the same cycle that `result_valid_o` is asserted.
- R3: Without the busy indicator, the serial clock starts low when readout begins and has a period of 2·SCK_HALF cycles. Its first rising edge comes exactly CONV_WAIT + SCK_HALF cycles after the convert rising edge.
- R4: With the busy indicator, readout begins on the first low-to-high transition of `adc_sdo_i` seen while converting, whether it comes before or after CONV_WAIT cycles. The first serial clock rising edge comes SCK_HALF + 1 cycles after the cycle in which `adc_sdo_i` first reads high.
- R5: Each conversion has exactly 16·N_DEV serial clock rising edges while convert is high without the busy indicator, and 16·N_DEV + 1 with it.
- R6: `adc_sdo_i` is sampled once per pulse, in the last system cycle of the clock's high phase, just before its falling edge. In busy mode the first sampled bit (the busy flag) is discarded.
- R7: The first 16 kept bits belong to the converter nearest the host and appear in `result_o[15:0]`, MSB first. Converter k (k = 0 nearest) appears in `result_o[16k+15:16k]`.
- R8: `result_valid_o` is a single-cycle strobe. `result_o` holds its value until the next strobe.
- R9: After convert falls it stays low for at least ACQ_CYCLES cycles. With start held high it rises again exactly ACQ_CYCLES + 2 cycles after falling. Start requests during conversion, readout or acquisition are dropped and never start a later sequence.
- R10: During and right after reset, convert, serial clock and strobe are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one convert-and-read sequence |
| busy_en_i | input | 1 | 1 selects busy-indicator operation, latched at start |
| adc_sdo_i | input | 1 | Serial data returning from the converter nearest the host |
| adc_cnv_o | output | 1 | Convert line to all converters |
| adc_sck_o | output | 1 | Serial clock to all converters |
| result_o | output | 16·N_DEV | Converter words, converter k at bits [16k+15:16k] |
| result_valid_o | output | 1 | One-cycle strobe marking new results |

## Verification
Two functions can land on the same cycle.

The first pair is the capture of the last bit, which also ends the readout and raises the strobe, and a new start request. To provoke it, start is asserted through the final high phase and the strobe cycle, then pulsed again in the first acquisition cycle. The bench judges the collision by confirming that the results are correct and that no further convert edge appears in the next forty cycles.

The second pair is the end of the acquisition window and a start that is held high. Here the bench measures the exact gap between convert falling and rising again.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CONV,
        ST_SHIFT,
        ST_ACQ
    } seq_state_e;

    // Number of serial clock pulses needed to drain a chain of n words of w bits.
    function automatic int unsigned chain_pulses(int unsigned n, int unsigned w, logic busy);
        return n * w + (busy ? 32'd1 : 32'd0);
    endfunction

endpackage

// File: rtl/adc_sck_tick.sv
module adc_sck_tick #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sck_o,
    output logic fall_o
);
    localparam int PH_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [PH_W-1:0] ph_q;
    logic            lvl_q;
    logic            wrap;

    assign wrap   = (ph_q == PH_W'(SCK_HALF - 1));
    assign sck_o  = lvl_q;
    // last cycle of a high phase: the sample point ahead of the falling edge
    assign fall_o = run_i & lvl_q & wrap;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            ph_q  <= '0;
            lvl_q <= 1'b0;
        end else if (wrap) begin
            ph_q  <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            ph_q  <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  logic                    cap_i,
    input  logic                    drop_first_i,
    input  logic                    bit_i,
    output logic                    last_o,
    output logic [N_DEV*WORD_W-1:0] data_o,
    output logic                    valid_o
);
    import chain_adc_pkg::*;

    localparam int TOTAL = N_DEV * WORD_W;
    localparam int CW    = $clog2(TOTAL + 2);

    logic [CW-1:0]    cnt_q;
    logic [TOTAL-1:0] sreg_q;
    logic [TOTAL-1:0] sreg_next;
    logic [TOTAL-1:0] slot_next;
    logic [TOTAL-1:0] out_q;
    logic             valid_q;
    logic             keep;
    logic [CW-1:0]    last_cnt;

    assign last_cnt  = CW'(chain_pulses(N_DEV, WORD_W, drop_first_i) - 1);
    assign last_o    = cap_i & (cnt_q == last_cnt);
    assign keep      = ~(drop_first_i & (cnt_q == '0));
    assign sreg_next = {sreg_q[TOTAL-2:0], bit_i};

    // the oldest word in the shift register belongs to the nearest converter
    for (genvar k = 0; k < N_DEV; k++) begin : g_slot
        assign slot_next[k*WORD_W +: WORD_W] = sreg_next[(N_DEV-1-k)*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sreg_q  <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= last_o;
            if (clear_i)
                cnt_q <= '0;
            else if (cap_i)
                cnt_q <= cnt_q + 1'b1;
            if (cap_i && keep)
                sreg_q <= sreg_next;
            if (last_o)
                out_q <= slot_next;
        end
    end

    assign data_o  = out_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int CONV_WAIT  = 12,
    parameter int ACQ_CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic busy_en_i,
    input  logic sdo_i,
    input  logic last_i,
    output logic cnv_o,
    output logic hold_o,
    output logic shift_o,
    output logic mode_o
);
    import chain_adc_pkg::*;

    localparam int CNT_MAX = (CONV_WAIT > ACQ_CYCLES) ? CONV_WAIT : ACQ_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mode_q;
    logic             hold_q;
    logic             sdo_q;
    logic             busy_edge;
    logic             conv_done;

    assign busy_edge = sdo_i & ~sdo_q;
    assign conv_done = mode_q ? busy_edge : (cnt_q == CNT_W'(CONV_WAIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            hold_q  <= 1'b0;
            sdo_q   <= 1'b0;
        end else begin
            sdo_q <= sdo_i;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= busy_en_i;
                        hold_q  <= busy_en_i;
                        state_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    cnt_q   <= '0;
                    state_q <= ST_CONV;
                end
                ST_CONV: begin
                    hold_q <= 1'b0;
                    cnt_q  <= cnt_q + 1'b1;
                    if (conv_done)
                        state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (last_i) begin
                        cnt_q   <= '0;
                        state_q <= ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(ACQ_CYCLES - 1))
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cnv_o   = (state_q == ST_CONV) || (state_q == ST_SHIFT);
    assign shift_o = (state_q == ST_SHIFT);
    assign hold_o  = hold_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
    parameter int N_DEV      = 3,
    parameter int WORD_W     = 16,
    parameter int SCK_HALF   = 2,
    parameter int CONV_WAIT  = 12,
    parameter int ACQ_CYCLES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    busy_en_i,
    input  logic                    adc_sdo_i,
    output logic                    adc_cnv_o,
    output logic                    adc_sck_o,
    output logic [N_DEV*WORD_W-1:0] result_o,
    output logic                    result_valid_o
);
    logic seq_hold;
    logic seq_shift;
    logic seq_mode;
    logic div_sck;
    logic div_fall;
    logic rx_last;

    adc_seq_ctrl #(
        .CONV_WAIT (CONV_WAIT),
        .ACQ_CYCLES(ACQ_CYCLES)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_en_i(busy_en_i),
        .sdo_i    (adc_sdo_i),
        .last_i   (rx_last),
        .cnv_o    (adc_cnv_o),
        .hold_o   (seq_hold),
        .shift_o  (seq_shift),
        .mode_o   (seq_mode)
    );

    adc_sck_tick #(
        .SCK_HALF(SCK_HALF)
    ) i_tick (
        .clk   (clk),
        .rst   (rst),
        .run_i (seq_shift),
        .sck_o (div_sck),
        .fall_o(div_fall)
    );

    adc_shift_in #(
        .N_DEV (N_DEV),
        .WORD_W(WORD_W)
    ) i_rx (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (~seq_shift),
        .cap_i       (div_fall),
        .drop_first_i(seq_mode),
        .bit_i       (adc_sdo_i),
        .last_o      (rx_last),
        .data_o      (result_o),
        .valid_o     (result_valid_o)
    );

    // mode level is only present around the convert edge, divider only in readout
    assign adc_sck_o = seq_hold | div_sck;
endmodule

// File: rtl/chain_adc_reader_chk.sv
module chain_adc_reader_chk #(
    parameter int N_DEV      = 3,
    parameter int WORD_W     = 16,
    parameter int CONV_WAIT  = 12,
    parameter int ACQ_CYCLES = 6
) (
    input logic clk,
    input logic rst,
    input logic cnv,
    input logic sck,
    input logic valid,
    input logic mode
);
    localparam int TOT = N_DEV * WORD_W;
    localparam int CW  = $clog2(TOT + 2) + 1;
    localparam int WM  = (CONV_WAIT > ACQ_CYCLES) ? CONV_WAIT : ACQ_CYCLES;
    localparam int WW  = $clog2(WM + 2) + 1;

    logic          cnv_d;
    logic          sck_d;
    logic [CW-1:0] rise_cnt;
    logic [WW-1:0] hi_cnt;
    logic [WW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_d    <= 1'b0;
            sck_d    <= 1'b0;
            rise_cnt <= '0;
            hi_cnt   <= '0;
            low_cnt  <= WW'(ACQ_CYCLES);
        end else begin
            cnv_d <= cnv;
            sck_d <= sck;
            if (cnv && !cnv_d)
                rise_cnt <= '0;
            else if (cnv && sck && !sck_d)
                rise_cnt <= rise_cnt + 1'b1;
            if (!cnv)
                hi_cnt <= '0;
            else if (hi_cnt < WW'(CONV_WAIT))
                hi_cnt <= hi_cnt + 1'b1;
            if (cnv)
                low_cnt <= '0;
            else if (low_cnt < WW'(ACQ_CYCLES))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r1_sck_level_at_convert: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> (sck == mode));

    a_r2_cnv_drops_with_valid: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!cnv && $past(cnv)));

    a_r3_conv_wait_respected: assert property (@(posedge clk) disable iff (rst)
        (!mode && cnv && sck && !sck_d) |-> (hi_cnt >= WW'(CONV_WAIT)));

    a_r5_clock_count: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv) |-> (rise_cnt == (mode ? CW'(TOT + 1) : CW'(TOT))));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r9_acquisition_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> (low_cnt >= WW'(ACQ_CYCLES)));
endmodule

bind chain_adc_reader chain_adc_reader_chk #(
    .N_DEV     (N_DEV),
    .WORD_W    (WORD_W),
    .CONV_WAIT (CONV_WAIT),
    .ACQ_CYCLES(ACQ_CYCLES)
) i_chk (
    .clk  (clk),
    .rst  (rst),
    .cnv  (adc_cnv_o),
    .sck  (adc_sck_o),
    .valid(result_valid_o),
    .mode (seq_mode)
);

// File: tb/test_chain_adc_reader.sv
module test_chain_adc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEV      = 3;
    localparam int WORD_W     = 16;
    localparam int SCK_HALF   = 2;
    localparam int CONV_WAIT  = 12;
    localparam int ACQ_CYCLES = 6;
    localparam int TOT        = N_DEV * WORD_W;

    // {busy, ready delay, word nearest, middle word, farthest word}
    localparam logic [56:0] VEC [4] = '{
        {1'b0, 8'd5,  16'hA5C3, 16'h0001, 16'h8000},
        {1'b1, 8'd4,  16'hFFFF, 16'h7FFE, 16'h1234},
        {1'b1, 8'd20, 16'h0000, 16'hFFFF, 16'h5A5A},
        {1'b0, 8'd3,  16'h8001, 16'h7FFF, 16'hC0DE}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy_en = 1'b0;
    logic sdo = 1'b0;
    logic cnv, sck, valid;
    logic [TOT-1:0] res;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chain_adc_reader #(
        .N_DEV(N_DEV), .WORD_W(WORD_W), .SCK_HALF(SCK_HALF),
        .CONV_WAIT(CONV_WAIT), .ACQ_CYCLES(ACQ_CYCLES)
    ) i_chain_adc_reader (
        .clk(clk), .rst(rst), .start_i(start), .busy_en_i(busy_en),
        .adc_sdo_i(sdo), .adc_cnv_o(cnv), .adc_sck_o(sck),
        .result_o(res), .result_valid_o(valid)
    );

    // converter chain model: returning line of the nearest converter
    logic           cur_busy = 1'b0;
    int             cur_dly = 4;
    logic [TOT-1:0] cur_words = '0;
    int             busy_cyc = 0;
    logic [TOT:0]   sh;

    always begin
        @(posedge cnv);
        sdo = 1'b0;
        repeat (cur_dly) @(negedge clk);
        sh = cur_busy ? {1'b1, cur_words} : {cur_words, 1'b0};
        sdo = sh[TOT];
        busy_cyc = cyc;
        while (cnv) begin
            @(negedge sck or negedge cnv);
            if (cnv) begin
                sh = sh << 1;
                sdo = sh[TOT];
            end
        end
    end

    // port monitor
    logic prev_cnv = 1'b0, prev_sck = 1'b0, sck_at_rise = 1'b0;
    int cnv_rises = 0, sck_rises = 0, rise_cyc = 0, first_sck = 0, fall_cyc = 0, valid_cyc = 0;

    always @(negedge clk) begin
        if (cnv && !prev_cnv) begin
            cnv_rises++;
            rise_cyc = cyc;
            sck_at_rise = sck;
            sck_rises = 0;
            first_sck = -1;
        end
        if (cnv && sck && !prev_sck) begin
            if (sck_rises == 0) first_sck = cyc;
            sck_rises++;
        end
        if (!cnv && prev_cnv) fall_cyc = cyc;
        if (valid) valid_cyc = cyc;
        prev_cnv = cnv;
        prev_sck = sck;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_valid();
        int n = 0;
        do begin
            tick();
            n++;
        end while (!valid && n < 3000);
        check(valid, "R8 strobe never seen", 64'(valid), 64'd1);
    endtask

    task automatic load_vec(input int i);
        cur_busy  = VEC[i][56];
        cur_dly   = int'(VEC[i][55:48]);
        cur_words = VEC[i][47:0];
    endtask

    function automatic logic [TOT-1:0] expect_res();
        return {cur_words[15:0], cur_words[31:16], cur_words[47:32]};
    endfunction

    initial begin
        // R10 reset state
        repeat (3) tick();
        check(cnv == 1'b0, "R10 cnv in reset", 64'(cnv), 64'd0);
        check(sck == 1'b0, "R10 sck in reset", 64'(sck), 64'd0);
        check(valid == 1'b0, "R10 valid in reset", 64'(valid), 64'd0);
        check(res == '0, "R10 result in reset", 64'(res), 64'd0);
        @(negedge clk) rst = 1'b0;
        repeat (2) tick();
        check(cnv == 1'b0 && sck == 1'b0, "R10 idle after reset", {62'd0, cnv, sck}, 64'd0);

        // table walk
        for (int i = 0; i < 4; i++) begin
            load_vec(i);
            @(negedge clk);
            busy_en = cur_busy;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            busy_en = ~cur_busy;          // R1 later change must not matter
            wait_valid();
            check(res == expect_res(), "R6 R7 result words", 64'(res), 64'(expect_res()));
            check(sck_at_rise == cur_busy, "R1 sck level at convert", 64'(sck_at_rise), 64'(cur_busy));
            check(sck_rises == TOT + int'(cur_busy), "R5 clock count", 64'(sck_rises), 64'(TOT + int'(cur_busy)));
            check(valid_cyc == fall_cyc, "R2 cnv falls with strobe", 64'(fall_cyc), 64'(valid_cyc));
            if (!cur_busy)
                check(first_sck - rise_cyc == CONV_WAIT + SCK_HALF, "R3 first clock delay",
                      64'(first_sck - rise_cyc), 64'(CONV_WAIT + SCK_HALF));
            else
                check(first_sck - busy_cyc == SCK_HALF + 1, "R4 clock after busy edge",
                      64'(first_sck - busy_cyc), 64'(SCK_HALF + 1));
            tick();
            check(valid == 1'b0, "R8 strobe single cycle", 64'(valid), 64'd0);
            repeat (ACQ_CYCLES + 4) tick();
        end

        // start during readout is dropped; results hold
        begin
            int n0;
            n0 = cnv_rises;
            load_vec(0);
            @(negedge clk); busy_en = 1'b0; start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (sck_rises < 10) tick();
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            wait_valid();
            repeat (40) tick();
            check(cnv_rises == n0 + 1, "R9 start in readout dropped", 64'(cnv_rises), 64'(n0 + 1));
            check(res == expect_res(), "R8 result held", 64'(res), 64'(expect_res()));
        end

        // start held high across two sequences: exact acquisition gap
        begin
            int n1, f1;
            load_vec(1);
            @(negedge clk); busy_en = 1'b1; start = 1'b1;
            wait_valid();
            f1 = fall_cyc;
            n1 = cnv_rises;
            while (cnv_rises == n1) tick();
            start = 1'b0;
            check(rise_cyc - f1 == ACQ_CYCLES + 2, "R9 acquisition gap", 64'(rise_cyc - f1), 64'(ACQ_CYCLES + 2));
            wait_valid();
            check(res == expect_res(), "R7 result after back-to-back", 64'(res), 64'(expect_res()));
            repeat (ACQ_CYCLES + 4) tick();
        end

        // start coinciding with last capture and strobe, then in acquisition
        begin
            int n2;
            load_vec(2);
            @(negedge clk); busy_en = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (sck_rises < TOT + 1) tick();
            start = 1'b1;
            while (!valid) tick();
            start = 1'b0;
            check(res == expect_res(), "R6 result at collision", 64'(res), 64'(expect_res()));
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            n2 = cnv_rises;
            repeat (40) tick();
            check(cnv_rises == n2, "R9 start at strobe dropped", 64'(cnv_rises), 64'(n2));
            check(cnv == 1'b0 && sck == 1'b0, "R10 idle levels", {62'd0, cnv, sck}, 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule